// File: doc/BRIEF.md
# Bayer Histogram with White-Balance Gain

This block builds a histogram of raw colour-filter-array pixels over one or more frames. Pixels arrive on a valid/ready stream. In unpacked mode each 16-bit word carries one pixel of up to 14 bits. In packed mode each word carries two 8-bit pixels, which the block consumes over two cycles. The block keeps its own column and row counters against the programmed frame size. The row and column parities, combined with a pattern selector, pick one of four gain slots.

Each pixel is multiplied by the gain of its slot, clipped to the 14-bit range and shifted right by a programmable amount. The result is clipped to the bin range, and the matching bin counter is incremented. Bin counters are read back through a registered read port. A clear request drains the pipeline and then zeroes every bin, one per cycle. The same clear runs by itself after reset.

Top module: `bayer_hist`

## Requirements
- R1: After reset, `busy` is high and `in_ready` is low for exactly 1024 cycles while all bins are zeroed. After that, every bin reads 0 and `in_ready` is high.
- R2: With `cfg_packed`=0, each accepted word supplies one pixel, `in_data[13:0]`. Bits 15:14 are ignored.
- R3: With `cfg_packed`=1, an accepted word supplies pixel `in_data[7:0]` in that cycle and pixel `in_data[15:8]` in the next cycle. `in_ready` is low in that next cycle.
- R4: The column counts from 0 to `cfg_width`-1 and then wraps, advancing the row. The row wraps after `cfg_height`-1. The gain slot is `{row[0],col[0]} XOR cfg_pattern`. `frame_done` pulses for one cycle, in the cycle after the last pixel of a frame is taken.
- R5: Gain slot s is `cfg_gains[8s+7:8s]`, unsigned with 5 fractional bits. The scaled pixel is floor(pixel*gain/32), clipped to 16383.
- R6: The bin index is the scaled pixel shifted right by `cfg_shift` (0 to 7), clipped to 1023.
- R7: A bin counter stops at 2^CNT_W-1 and never wraps.
- R8: Pixels that hit the same bin on consecutive cycles each add one. No increment is lost.
- R9: A `clear_req` pulse while idle raises `busy` and drops `in_ready`. The block lets queued pixels finish, then zeroes all bins. It restarts the position at column 0, row 0.
- R10: `rd_data` holds the count of bin `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input word (one or two pixels) |
| in_ready | output | 1 | Block can take a word |
| cfg_packed | input | 1 | 1: two 8-bit pixels per word |
| cfg_pattern | input | 2 | XOR applied to the parity slot |
| cfg_width | input | 14 | Pixels per row (nonzero) |
| cfg_height | input | 14 | Rows per frame (nonzero) |
| cfg_gains | input | 32 | Four 8-bit gains, slot 0 in the low byte |
| cfg_shift | input | 3 | Right shift before binning |
| clear_req | input | 1 | Start a clear of all bins |
| busy | output | 1 | Clear in progress or pending |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| rd_addr | input | 10 | Bin to read |
| rd_data | output | CNT_W (20) | Count of the addressed bin |

## Verification
The assertions take it for granted that the configuration inputs stay fixed while pixels are in flight, and that width and height are nonzero. Under those conditions the frame-pulse and packing properties have a meaning. The stimulus changes the configuration only after the stream has gone idle and the pipeline has had several cycles to empty. It only asks for a clear while no word is being offered. The bench runs with a 6-bit counter, so that bin saturation can be reached within a short run. Its histogram model is rebuilt from the slot, gain, clip and shift rules rather than from the design.

// File: rtl/bayer_hist_pkg.sv
package bayer_hist_pkg;
  localparam int PIX_W     = 14;
  localparam int WORD_W    = 16;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 5;
  localparam int SHIFT_W   = 3;
  localparam int SLOTS     = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_CLEAR} clr_state_t;

  // gain is unsigned with GAIN_FRAC fractional bits; result clipped to PIX_W bits
  function automatic logic [PIX_W-1:0] wb_scale(input logic [PIX_W-1:0] pix,
                                               input logic [GAIN_W-1:0] gain);
    logic [PIX_W+GAIN_W-1:0] prod;
    logic [PIX_W+GAIN_W-GAIN_FRAC-1:0] q;
    prod = {{GAIN_W{1'b0}}, pix} * {{PIX_W{1'b0}}, gain};
    q = prod[PIX_W+GAIN_W-1:GAIN_FRAC];
    if (|q[PIX_W+GAIN_W-GAIN_FRAC-1:PIX_W]) return {PIX_W{1'b1}};
    return q[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/bh_position.sv
module bh_position #(
  parameter int DIM_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  output logic [1:0]       parity,
  output logic             frame_done
);
  logic [DIM_W-1:0] col, row;
  logic last_col, last_row;

  assign last_col = (col == cfg_width - 1'b1);
  assign last_row = (row == cfg_height - 1'b1);
  assign parity   = {row[0], col[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col        <= '0;
      row        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (restart) begin
        col <= '0;
        row <= '0;
      end else if (step) begin
        if (last_col) begin
          col <= '0;
          if (last_row) begin
            row        <= '0;
            frame_done <= 1'b1;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bh_scaler.sv
module bh_scaler
  import bayer_hist_pkg::*;
#(
  parameter int BIN_AW = 10
) (
  input  logic [PIX_W-1:0]        pix,
  input  logic [1:0]              parity,
  input  logic [1:0]              pattern,
  input  logic [SLOTS*GAIN_W-1:0] gains,
  input  logic [SHIFT_W-1:0]      shift,
  output logic [BIN_AW-1:0]       bin
);
  logic [1:0]        slot;
  logic [GAIN_W-1:0] gain;
  logic [PIX_W-1:0]  scaled, shifted;

  assign slot    = parity ^ pattern;
  assign gain    = gains[slot*GAIN_W +: GAIN_W];
  assign scaled  = wb_scale(pix, gain);
  assign shifted = scaled >> shift;

  generate
    if (BIN_AW >= PIX_W) begin : g_wide
      assign bin = BIN_AW'(shifted);
    end else begin : g_clip
      assign bin = (|shifted[PIX_W-1:BIN_AW]) ? {BIN_AW{1'b1}} : shifted[BIN_AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/bh_bin_mem.sv
module bh_bin_mem
  import bayer_hist_pkg::*;
#(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [BIN_AW-1:0] upd_bin,
  input  logic              clear_req,
  input  logic              src_pending,
  input  logic [BIN_AW-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              busy,
  output logic              clr_we,
  output logic [BIN_AW-1:0] clr_idx,
  output logic              upd_we,
  output logic [CNT_W-1:0]  upd_wdata
);
  localparam int BINS = 1 << BIN_AW;
  localparam logic [BIN_AW-1:0] LAST_BIN = BIN_AW'(BINS - 1);

  logic [CNT_W-1:0]  mem [BINS];
  logic              s1_v, s2_v, fwd_v;
  logic [BIN_AW-1:0] s1_bin, s2_bin, fwd_bin;
  logic [CNT_W-1:0]  s2_rd, fwd_val, old_cnt;
  clr_state_t        state;
  logic              pipe_empty;

  // read of a bin written on the previous edge returns stale data: forward it
  assign old_cnt    = (fwd_v && fwd_bin == s2_bin) ? fwd_val : s2_rd;
  assign upd_wdata  = (&old_cnt) ? old_cnt : old_cnt + 1'b1;
  assign upd_we     = s2_v;
  assign clr_we     = (state == ST_CLEAR);
  assign busy       = (state != ST_IDLE);
  assign pipe_empty = !s1_v && !s2_v;

  always_ff @(posedge clk) begin
    s2_rd   <= mem[s1_bin];
    rd_data <= mem[rd_addr];
    if (clr_we) mem[clr_idx] <= '0;
    else if (upd_we) mem[s2_bin] <= upd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      fwd_v   <= 1'b0;
      s1_bin  <= '0;
      s2_bin  <= '0;
      fwd_bin <= '0;
      fwd_val <= '0;
    end else begin
      s1_v    <= upd_valid;
      s1_bin  <= upd_bin;
      s2_v    <= s1_v;
      s2_bin  <= s1_bin;
      fwd_v   <= upd_we;
      fwd_bin <= s2_bin;
      fwd_val <= upd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CLEAR;
      clr_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (clear_req) state <= ST_DRAIN;
        ST_DRAIN: if (pipe_empty && !src_pending && !upd_valid) begin
          state   <= ST_CLEAR;
          clr_idx <= '0;
        end
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST_BIN) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bayer_hist.sv
module bayer_hist
  import bayer_hist_pkg::*;
#(
  parameter int DIM_W  = 14,
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic                    cfg_packed,
  input  logic [1:0]              cfg_pattern,
  input  logic [DIM_W-1:0]        cfg_width,
  input  logic [DIM_W-1:0]        cfg_height,
  input  logic [SLOTS*GAIN_W-1:0] cfg_gains,
  input  logic [SHIFT_W-1:0]      cfg_shift,
  input  logic                    clear_req,
  output logic                    busy,
  output logic                    frame_done,
  input  logic [BIN_AW-1:0]       rd_addr,
  output logic [CNT_W-1:0]        rd_data
);
  logic              hold_v;
  logic [7:0]        hold_byte;
  logic              accept, pix_fire;
  logic [PIX_W-1:0]  pix;
  logic [1:0]        parity;
  logic [BIN_AW-1:0] bin;
  logic              clr_we, upd_we;
  logic [BIN_AW-1:0] clr_idx;
  logic [CNT_W-1:0]  upd_wdata;

  assign in_ready = !busy && !hold_v;
  assign accept   = in_valid && in_ready;
  assign pix_fire = hold_v || accept;
  assign pix      = hold_v     ? PIX_W'(hold_byte) :
                    cfg_packed ? PIX_W'(in_data[7:0]) : in_data[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_byte <= '0;
    end else begin
      hold_v <= accept && cfg_packed;
      if (accept) hold_byte <= in_data[15:8];
    end
  end

  bh_position #(.DIM_W(DIM_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .restart(clr_we), .step(pix_fire),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .parity(parity), .frame_done(frame_done)
  );

  bh_scaler #(.BIN_AW(BIN_AW)) u_scale (
    .pix(pix), .parity(parity), .pattern(cfg_pattern),
    .gains(cfg_gains), .shift(cfg_shift), .bin(bin)
  );

  bh_bin_mem #(.BIN_AW(BIN_AW), .CNT_W(CNT_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .upd_valid(pix_fire), .upd_bin(bin),
    .clear_req(clear_req), .src_pending(hold_v),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .clr_we(clr_we), .clr_idx(clr_idx), .upd_we(upd_we), .upd_wdata(upd_wdata)
  );
endmodule

// File: rtl/bayer_hist_checker.sv
module bayer_hist_checker #(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_packed,
  input logic              busy,
  input logic              frame_done,
  input logic              pix_fire,
  input logic              upd_we,
  input logic              clr_we,
  input logic [BIN_AW-1:0] clr_idx,
  input logic [CNT_W-1:0]  upd_wdata
);
  localparam logic [BIN_AW-1:0] LAST_BIN = {BIN_AW{1'b1}};

  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_second_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_packed) |=> (!in_ready && pix_fire));

  p_frame_after_pixel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(pix_fire));

  p_single_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_we && clr_we));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> (upd_wdata != '0));

  p_clear_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_idx != '0) |-> ($past(clr_we) && clr_idx == $past(clr_idx) + 1'b1));

  p_clear_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(clr_idx) == LAST_BIN));
endmodule

bind bayer_hist bayer_hist_checker #(.BIN_AW(BIN_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_packed(cfg_packed), .busy(busy), .frame_done(frame_done),
  .pix_fire(pix_fire), .upd_we(upd_we), .clr_we(clr_we),
  .clr_idx(clr_idx), .upd_wdata(upd_wdata)
);

// File: tb/bayer_hist_bench.sv
`timescale 1ns/1ps
module bayer_hist_bench;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NB   = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        cfg_packed = 1'b0;
  logic [1:0]  cfg_pattern = '0;
  logic [13:0] cfg_width = 14'd4;
  logic [13:0] cfg_height = 14'd4;
  logic [31:0] cfg_gains = {4{8'h20}};
  logic [2:0]  cfg_shift = '0;
  logic        clear_req = 1'b0;
  logic        busy, frame_done;
  logic [9:0]  rd_addr = '0;
  logic [CW-1:0] rd_data;

  int total = 0, bad = 0;
  int exp_cnt[NB];
  int bcol = 0, brow = 0, bw = 4, bh = 4, bpat = 0, bsh = 0;
  int bg[4];
  int frames_exp = 0, frames_seen = 0;

  always #10 clk = ~clk;

  bayer_hist #(.CNT_W(CW)) u_bayer_hist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_packed(cfg_packed), .cfg_pattern(cfg_pattern),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_gains(cfg_gains),
    .cfg_shift(cfg_shift), .clear_req(clear_req), .busy(busy),
    .frame_done(frame_done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (rst_n && frame_done) frames_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_bin(input int p, input int g, input int s);
    int v;
    v = (p * g) / 32;
    if (v > 16383) v = 16383;
    v = v / (1 << s);
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic model_pix(input int p);
    int slot, b;
    slot = (((brow % 2) * 2) + (bcol % 2)) ^ bpat;
    b = ref_bin(p, bg[slot], bsh);
    if (exp_cnt[b] < CMAX) exp_cnt[b]++;
    bcol++;
    if (bcol == bw) begin
      bcol = 0;
      brow++;
      if (brow == bh) begin
        brow = 0;
        frames_exp++;
      end
    end
  endtask

  task automatic setup(input bit pk, input int pat, input int w, input int h,
                       input int g0, input int g1, input int g2, input int g3, input int s);
    cfg_packed = pk; cfg_pattern = 2'(pat); cfg_width = 14'(w); cfg_height = 14'(h);
    cfg_gains = {8'(g3), 8'(g2), 8'(g1), 8'(g0)}; cfg_shift = 3'(s);
    bpat = pat; bw = w; bh = h; bsh = s;
    bg[0] = g0; bg[1] = g1; bg[2] = g2; bg[3] = g3;
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic put_pix(input int p);
    model_pix(p);
    put({2'b10, 14'(p)});   // R2: top bits must be ignored
  endtask

  task automatic put_pair(input int lo, input int hi);
    model_pix(lo);
    model_pix(hi);
    put({8'(hi), 8'(lo)});
  endtask

  task automatic read_bin(input int a, output int v);
    @(negedge clk);
    rd_addr = 10'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic sweep(input string req);
    int v;
    for (int a = 0; a < NB; a++) begin
      read_bin(a, v);
      chk(v == exp_cnt[a], req, v, exp_cnt[a]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    chk(busy == 1'b1, "R9 busy after clear_req", int'(busy), 1);
    chk(in_ready == 1'b0, "R9 in_ready during clear", int'(in_ready), 0);
    while (busy) @(negedge clk);
    for (int i = 0; i < NB; i++) exp_cnt[i] = 0;
    bcol = 0; brow = 0;
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, v;
    for (int i = 0; i < NB; i++) exp_cnt[i] = 0;
    bg[0] = 32; bg[1] = 32; bg[2] = 32; bg[3] = 32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
    chk(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 1024, "R1 initial clear length", n, 1024);
    chk(in_ready == 1'b1, "R1 ready after clear", int'(in_ready), 1);
    sweep("R1 bins zero");

    // A: unpacked, unity gains, two 4x4 frames
    setup(0, 0, 4, 4, 32, 32, 32, 32, 0);
    for (int k = 0; k < 32; k++) put_pix((k * 37) % 1024);
    settle();
    chk(frames_seen == frames_exp, "R4 frame pulses A", frames_seen, frames_exp);
    sweep("R2 R10 unity histogram");

    // B: per-slot gains, pattern swap, shift 2, clipping, repeated bins
    setup(0, 2, 6, 3, 64, 16, 32, 255, 2);
    for (int k = 0; k < 24; k++) put_pix((k * 523) % 16384);
    put_pix(16383);
    for (int k = 0; k < 6; k++) put_pix(1000);
    settle();
    read_bin(1023, v);
    chk(v == exp_cnt[1023], "R5 R6 clip bin 1023", v, exp_cnt[1023]);
    sweep("R5 R6 gain and shift");

    // B2: large shift, pattern 3
    setup(0, 3, 3, 5, 200, 40, 8, 96, 7);
    for (int k = 0; k < 30; k++) put_pix((k * 911 + 77) % 16384);
    settle();
    chk(frames_seen == frames_exp, "R4 frame pulses B", frames_seen, frames_exp);
    sweep("R6 shift 7");

    // C: packed pairs with odd width
    do_clear();
    setup(1, 1, 5, 2, 32, 48, 20, 64, 0);
    for (int k = 0; k < 15; k++) put_pair((k * 29) % 256, (k * 71 + 5) % 256);
    settle();
    chk(frames_seen == frames_exp, "R3 R4 frame pulses packed", frames_seen, frames_exp);
    sweep("R3 packed histogram");

    // D: back-to-back same bin into saturation
    do_clear();
    setup(0, 0, 8, 8, 32, 32, 32, 32, 0);
    for (int k = 0; k < 70; k++) put_pix(100);
    settle();
    read_bin(100, v);
    chk(v == CMAX, "R7 R8 saturated count", v, CMAX);
    sweep("R7 R8 saturation sweep");

    // D2: short runs back-to-back, below saturation
    do_clear();
    for (int k = 0; k < 40; k++) put_pix(300 + (k / 5));
    settle();
    sweep("R8 consecutive hits");

    // E: clear in the middle of a frame restarts position
    setup(0, 0, 4, 4, 32, 64, 96, 128, 0);
    for (int k = 0; k < 3; k++) put_pix(50 + k);
    settle();
    n = frames_exp;
    do_clear();
    frames_exp = n;
    sweep("R9 bins zero after clear");
    for (int k = 0; k < 8; k++) put_pix(20);
    settle();
    chk(frames_seen == frames_exp, "R9 no frame pulse", frames_seen, frames_exp);
    sweep("R9 position restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule